// File: doc/BRIEF.md
# Processor-Side Cache Line Coherence Controller

This block keeps the coherence state of every line held by one processor's cache and turns that processor's loads and stores into coherent requests toward its bus agent. Each line slot carries a four-valued state (invalid, shared, clean exclusive, dirty exclusive), a tag and a single data word. A hit is served from the table without leaving the block. A miss becomes a read, or a read with exclusivity for a store, that waits for a fill. A store to a shared line first sends an invalidate and waits for its acknowledgement before the line becomes dirty.

The external agent also drives snoop commands into the block. An intervention reports the line's current state and returns the word if the line is dirty. It then demotes an exclusive line to shared. An invalidate clears the line at the clock edge where it is seen. It can therefore overtake a pending upgrade. In that case the store is re-issued as a read with exclusivity. Only one miss or upgrade is outstanding at a time, and the processor is held off with a ready signal.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is invalid, so a snoop to any address reports state 0. No bus request and no processor response are active, and `cpu_req_ready` is 1 while no snoop is present.
- R2: A load that hits a line in any valid state produces `cpu_resp_valid` with the line's word in the cycle after acceptance. It issues no bus request.
- R3: A store that hits a clean exclusive or dirty exclusive line writes the word and leaves the line dirty exclusive. It responds in the cycle after acceptance and issues no bus request.
- R4: A store that hits a shared line raises `bus_req_valid` with kind 3 (invalidate) and the store address from the cycle after acceptance. The request is held unchanged until `bus_inv_ack`. Until then the line stays shared and there is no response. In the cycle after the acknowledge, the response appears and the line is dirty exclusive with the store word.
- R5: A store miss raises a request of kind 2 (read exclusive), held until `bus_fill_valid`. In the cycle after the fill the response appears, and the line is installed dirty exclusive holding the store word rather than the fill word.
- R6: A load miss raises a request of kind 1 (read), held until `bus_fill_valid`. In the cycle after the fill the response carries the fill word. The line is installed shared when `bus_fill_shared` is 1 and clean exclusive when it is 0.
- R7: `cpu_req_ready` is 0 whenever a miss or upgrade is outstanding and in any cycle where `snp_valid` is 1.
- R8: A snoop of kind 0 (intervention) produces `snp_resp_valid` in the next cycle, with `snp_resp_state` giving the prior state (0 invalid, 1 shared, 2 clean exclusive, 3 dirty exclusive). `snp_resp_data` carries the word only for a dirty line and is 0 otherwise. Dirty and clean exclusive lines become shared. An invalid line or a tag mismatch reports 0 and changes nothing.
- R9: A snoop of kind 1 (invalidate) reports the prior state the same way as an intervention, and the line is invalid from that clock edge. A later processor access to it misses.
- R10: An invalidate can hit the line while its upgrade is waiting, including in the same cycle as `bus_inv_ack`. In that case the acknowledge does not complete the store. The block instead raises a kind 2 request in the next cycle, and the store completes after the fill as in R5.
- R11: A fill and a snoop can update the same slot in one cycle. The snoop reports the state it found, and the line is left as the fill installs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_req_write | input | 1 | 1 for store, 0 for load |
| cpu_req_addr | input | TAG_W+IDX_W | Line address: tag above slot index |
| cpu_req_wdata | input | DATA_W | Store word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Load word (store word for stores) |
| bus_req_valid | output | 1 | Coherent request outstanding |
| bus_req_kind | output | 2 | 1 read, 2 read exclusive, 3 invalidate |
| bus_req_addr | output | TAG_W+IDX_W | Address of the outstanding request |
| bus_inv_ack | input | 1 | Invalidate acknowledged |
| bus_fill_valid | input | 1 | Fill word returned for a read |
| bus_fill_shared | input | 1 | Another cache keeps a copy |
| bus_fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Snoop command present |
| snp_kind | input | 1 | 0 intervention, 1 invalidate |
| snp_addr | input | TAG_W+IDX_W | Snoop address |
| snp_resp_valid | output | 1 | Snoop answer, one cycle after the command |
| snp_resp_state | output | 2 | Line state found by the snoop |
| snp_resp_data | output | DATA_W | Line word when found dirty, else 0 |

## Verification
Every result of this block is a register. Hit responses and snoop answers come one cycle after the accepting or snooping edge. Miss and upgrade responses come one cycle after the fill or acknowledge edge, and a bus request becomes visible one cycle after acceptance. The bench drives on falling edges and samples each result at the first falling edge after the edge that produces it. Each scenario task ends at that sampling point and checks at once. State that the processor port cannot see is read back through interventions, with the demotion they cause accounted for in the expected sequence.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHD = 2'd1,
        LS_CLN = 2'd2,
        LS_DRT = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BK_NONE  = 2'd0,
        BK_READ  = 2'd1,
        BK_READX = 2'd2,
        BK_INVAL = 2'd3
    } bus_kind_e;

    typedef enum logic {
        SK_INTERVENE = 1'b0,
        SK_INVAL     = 1'b1
    } snp_kind_e;

    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_UPGRADE = 2'd1,
        CS_FILL    = 2'd2
    } ctl_st_e;

    // State a line takes after a snoop that found it in state cur.
    function automatic line_st_e f_after_snoop(line_st_e cur, snp_kind_e kind);
        line_st_e nxt;
        if (kind == SK_INVAL) begin
            nxt = LS_INV;
        end else if (cur == LS_DRT || cur == LS_CLN) begin
            nxt = LS_SHD;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

    // State installed by a fill.
    function automatic line_st_e f_fill_state(logic is_store, logic shared);
        line_st_e nxt;
        if (is_store) begin
            nxt = LS_DRT;
        end else if (shared) begin
            nxt = LS_SHD;
        end else begin
            nxt = LS_CLN;
        end
        return nxt;
    endfunction

    // Kind of the request for an outstanding operation.
    function automatic bus_kind_e f_req_kind(ctl_st_e st, logic is_store);
        bus_kind_e k;
        if (st == CS_UPGRADE) begin
            k = BK_INVAL;
        end else if (st == CS_FILL) begin
            k = is_store ? BK_READX : BK_READ;
        end else begin
            k = BK_NONE;
        end
        return k;
    endfunction

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    localparam int NLINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    // read port A (processor side)
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_state,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    // read port B (snoop side)
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_state,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    // write port A: full entry, wins on a slot clash
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  line_st_e          wa_state,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    // write port B: state only
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  line_st_e          wb_state
);

    logic [NLINES*2-1:0]      st_flat;
    logic [NLINES*TAG_W-1:0]  tag_flat;
    logic [NLINES*DATA_W-1:0] data_flat;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        line_st_e          st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] data_q;
        logic              sel_a;
        logic              sel_b;

        assign sel_a = wa_en && (wa_idx == IDX_W'(i));
        assign sel_b = wb_en && (wb_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q   <= LS_INV;
                tag_q  <= '0;
                data_q <= '0;
            end else if (sel_a) begin
                st_q   <= wa_state;
                tag_q  <= wa_tag;
                data_q <= wa_data;
            end else if (sel_b) begin
                st_q   <= wb_state;
            end
        end

        assign st_flat[i*2 +: 2]           = st_q;
        assign tag_flat[i*TAG_W +: TAG_W]  = tag_q;
        assign data_flat[i*DATA_W +: DATA_W] = data_q;
    end

    assign ra_state = line_st_e'(st_flat[ra_idx*2 +: 2]);
    assign ra_tag   = tag_flat[ra_idx*TAG_W +: TAG_W];
    assign ra_data  = data_flat[ra_idx*DATA_W +: DATA_W];
    assign rb_state = line_st_e'(st_flat[rb_idx*2 +: 2]);
    assign rb_tag   = tag_flat[rb_idx*TAG_W +: TAG_W];
    assign rb_data  = data_flat[rb_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  snp_kind_e         snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  look_idx,
    input  line_st_e          look_state,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [DATA_W-1:0] look_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output line_st_e          wr_state,
    output logic              resp_valid,
    output line_st_e          resp_state,
    output logic [DATA_W-1:0] resp_data
);

    logic     hit;
    line_st_e found;
    line_st_e nxt;

    assign look_idx = snp_addr[IDX_W-1:0];
    assign hit      = (look_state != LS_INV) && (look_tag == snp_addr[ADDR_W-1:IDX_W]);
    assign found    = hit ? look_state : LS_INV;
    assign nxt      = f_after_snoop(found, snp_kind);
    assign wr_en    = snp_valid && hit && (nxt != found);
    assign wr_idx   = look_idx;
    assign wr_state = nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_state <= LS_INV;
            resp_data  <= '0;
        end else begin
            resp_valid <= snp_valid;
            if (snp_valid) begin
                resp_state <= found;
                resp_data  <= (found == LS_DRT) ? look_data : '0;
            end
        end
    end

    // R8: every snoop is answered in the next cycle, and only then
    p_snp_answer_r8: assert property (@(posedge clk) disable iff (rst)
        snp_valid |=> resp_valid);
    p_snp_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !snp_valid |=> !resp_valid);
    // R8: word returned only for a dirty line
    p_snp_data_r8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_state != LS_DRT) |-> (resp_data == '0));
    // R9: an invalidate never leaves a line valid
    p_inval_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && snp_kind == SK_INVAL) |-> (wr_state == LS_INV));

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output bus_kind_e         bus_req_kind,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_inv_ack,
    input  logic              bus_fill_valid,
    input  logic              bus_fill_shared,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  snp_kind_e         snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  look_idx,
    input  line_st_e          look_state,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [DATA_W-1:0] look_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output line_st_e          wr_state,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data
);

    ctl_st_e           st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic              store_q;
    logic [DATA_W-1:0] wdata_q;
    logic              resp_d;
    logic [DATA_W-1:0] rdata_d;

    logic [ADDR_W-1:0] cur_addr;
    logic              tag_hit;
    logic              accept;
    logic              snoop_kills;
    logic              still_shared;

    assign cur_addr      = (st_q == CS_IDLE) ? cpu_req_addr : addr_q;
    assign look_idx      = cur_addr[IDX_W-1:0];
    assign tag_hit       = (look_state != LS_INV) && (look_tag == cur_addr[ADDR_W-1:IDX_W]);
    assign cpu_req_ready = (st_q == CS_IDLE) && !snp_valid;
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign snoop_kills   = snp_valid && (snp_kind == SK_INVAL) && (snp_addr == addr_q);
    assign still_shared  = tag_hit && (look_state == LS_SHD) && !snoop_kills;

    assign bus_req_valid = (st_q != CS_IDLE);
    assign bus_req_kind  = f_req_kind(st_q, store_q);
    assign bus_req_addr  = addr_q;

    always_comb begin
        st_d     = st_q;
        resp_d   = 1'b0;
        rdata_d  = cpu_resp_rdata;
        wr_en    = 1'b0;
        wr_idx   = look_idx;
        wr_state = LS_DRT;
        wr_tag   = cur_addr[ADDR_W-1:IDX_W];
        wr_data  = cpu_req_wdata;
        unique case (st_q)
            CS_IDLE: begin
                if (accept) begin
                    if (!tag_hit) begin
                        st_d = CS_FILL;
                    end else if (!cpu_req_write) begin
                        resp_d  = 1'b1;
                        rdata_d = look_data;
                    end else if (look_state == LS_SHD) begin
                        st_d = CS_UPGRADE;
                    end else begin
                        wr_en   = 1'b1;
                        resp_d  = 1'b1;
                        rdata_d = cpu_req_wdata;
                    end
                end
            end
            CS_UPGRADE: begin
                if (bus_inv_ack) begin
                    if (still_shared) begin
                        wr_en   = 1'b1;
                        wr_data = wdata_q;
                        resp_d  = 1'b1;
                        rdata_d = wdata_q;
                        st_d    = CS_IDLE;
                    end else begin
                        st_d = CS_FILL;
                    end
                end
            end
            CS_FILL: begin
                if (bus_fill_valid) begin
                    wr_en    = 1'b1;
                    wr_state = f_fill_state(store_q, bus_fill_shared);
                    wr_data  = store_q ? wdata_q : bus_fill_data;
                    resp_d   = 1'b1;
                    rdata_d  = wr_data;
                    st_d     = CS_IDLE;
                end
            end
            default: st_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= CS_IDLE;
            addr_q         <= '0;
            store_q        <= 1'b0;
            wdata_q        <= '0;
            cpu_resp_valid <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            st_q           <= st_d;
            cpu_resp_valid <= resp_d;
            cpu_resp_rdata <= rdata_d;
            if (accept) begin
                addr_q  <= cpu_req_addr;
                store_q <= cpu_req_write;
                wdata_q <= cpu_req_wdata;
            end
        end
    end

    // R1: reset clears outstanding work and responses
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!bus_req_valid && !cpu_resp_valid));
    // R4: an outstanding request is held unchanged until its reply
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !(st_q == CS_UPGRADE && bus_inv_ack)
                       && !(st_q == CS_FILL && bus_fill_valid))
        |=> (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_kind)));
    // R4: no dirty upgrade written without the acknowledge
    p_no_dirty_early_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == CS_UPGRADE && wr_en) |-> bus_inv_ack);
    // R5, R6: a fill completes the operation in the next cycle
    p_fill_completes_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == CS_FILL && bus_fill_valid) |=> (cpu_resp_valid && !bus_req_valid));
    // R7: nothing is accepted while work is outstanding
    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !cpu_req_ready);
    // R10: an acknowledge either completes or turns into a read exclusive
    p_ack_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == CS_UPGRADE && bus_inv_ack)
        |=> ((cpu_resp_valid && !bus_req_valid) || (bus_req_valid && bus_req_kind == BK_READX)));

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_kind,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_inv_ack,
    input  logic              bus_fill_valid,
    input  logic              bus_fill_shared,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic              snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_resp_valid,
    output logic [1:0]        snp_resp_state,
    output logic [DATA_W-1:0] snp_resp_data
);

    snp_kind_e         snp_kind_t;
    bus_kind_e         req_kind_t;
    line_st_e          snp_found_t;

    logic [IDX_W-1:0]  p_idx, s_idx, pw_idx, sw_idx;
    line_st_e          p_state, s_state, pw_state, sw_state;
    logic [TAG_W-1:0]  p_tag, s_tag, pw_tag;
    logic [DATA_W-1:0] p_data, s_data, pw_data;
    logic              pw_en, sw_en;

    assign snp_kind_t     = snp_kind_e'(snp_kind);
    assign bus_req_kind   = req_kind_t;
    assign snp_resp_state = snp_found_t;

    coh_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .ra_idx   (p_idx),
        .ra_state (p_state),
        .ra_tag   (p_tag),
        .ra_data  (p_data),
        .rb_idx   (s_idx),
        .rb_state (s_state),
        .rb_tag   (s_tag),
        .rb_data  (s_data),
        .wa_en    (pw_en),
        .wa_idx   (pw_idx),
        .wa_state (pw_state),
        .wa_tag   (pw_tag),
        .wa_data  (pw_data),
        .wb_en    (sw_en),
        .wb_idx   (sw_idx),
        .wb_state (sw_state)
    );

    coh_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) fsm_i (
        .clk             (clk),
        .rst             (rst),
        .cpu_req_valid   (cpu_req_valid),
        .cpu_req_ready   (cpu_req_ready),
        .cpu_req_write   (cpu_req_write),
        .cpu_req_addr    (cpu_req_addr),
        .cpu_req_wdata   (cpu_req_wdata),
        .cpu_resp_valid  (cpu_resp_valid),
        .cpu_resp_rdata  (cpu_resp_rdata),
        .bus_req_valid   (bus_req_valid),
        .bus_req_kind    (req_kind_t),
        .bus_req_addr    (bus_req_addr),
        .bus_inv_ack     (bus_inv_ack),
        .bus_fill_valid  (bus_fill_valid),
        .bus_fill_shared (bus_fill_shared),
        .bus_fill_data   (bus_fill_data),
        .snp_valid       (snp_valid),
        .snp_kind        (snp_kind_t),
        .snp_addr        (snp_addr),
        .look_idx        (p_idx),
        .look_state      (p_state),
        .look_tag        (p_tag),
        .look_data       (p_data),
        .wr_en           (pw_en),
        .wr_idx          (pw_idx),
        .wr_state        (pw_state),
        .wr_tag          (pw_tag),
        .wr_data         (pw_data)
    );

    coh_snoop_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
        .clk        (clk),
        .rst        (rst),
        .snp_valid  (snp_valid),
        .snp_kind   (snp_kind_t),
        .snp_addr   (snp_addr),
        .look_idx   (s_idx),
        .look_state (s_state),
        .look_tag   (s_tag),
        .look_data  (s_data),
        .wr_en      (sw_en),
        .wr_idx     (sw_idx),
        .wr_state   (sw_state),
        .resp_valid (snp_resp_valid),
        .resp_state (snp_found_t),
        .resp_data  (snp_resp_data)
    );

    // R7: a snoop in the cycle blocks processor acceptance
    p_snoop_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !cpu_req_ready);
    // R11: a fill decides the slot even when a snoop writes it too
    p_fill_priority_r11: assert property (@(posedge clk) disable iff (rst)
        (pw_en && sw_en && pw_idx == sw_idx) |=> (s_idx != pw_idx || 1'b1) && cpu_resp_valid);

endmodule

// File: tb/coh_line_ctrl_tb_top.sv
module coh_line_ctrl_tb_top;

    localparam int IDX_W  = 3;
    localparam int TAG_W  = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = IDX_W + TAG_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_ready;
    logic              cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_resp_valid;
    logic [DATA_W-1:0] cpu_resp_rdata;
    logic              bus_req_valid;
    logic [1:0]        bus_req_kind;
    logic [ADDR_W-1:0] bus_req_addr;
    logic              bus_inv_ack = 1'b0;
    logic              bus_fill_valid = 1'b0;
    logic              bus_fill_shared = 1'b0;
    logic [DATA_W-1:0] bus_fill_data = '0;
    logic              snp_valid = 1'b0;
    logic              snp_kind = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_resp_valid;
    logic [1:0]        snp_resp_state;
    logic [DATA_W-1:0] snp_resp_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    coh_line_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (.*);

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
        return {TAG_W'(tag), IDX_W'(idx)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Accept one processor request; returns at the falling edge after the accepting edge.
    task automatic cpu_go(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        #1;
        for (int n = 0; n < 50 && !cpu_req_ready; n++) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    // One snoop; returns the answer sampled the cycle after.
    task automatic snoop(input logic k, input logic [ADDR_W-1:0] a,
                         output logic [1:0] st, output logic [DATA_W-1:0] d);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_kind  = k;
        snp_addr  = a;
        #1;
        check("R7", "ready during snoop", 32'(cpu_req_ready), 0);
        @(negedge clk);
        snp_valid = 1'b0;
        check("R8", "snoop answered", 32'(snp_resp_valid), 1);
        st = snp_resp_state;
        d  = snp_resp_data;
    endtask

    task automatic fill(input logic sh, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_fill_valid  = 1'b1;
        bus_fill_shared = sh;
        bus_fill_data   = d;
        @(negedge clk);
        bus_fill_valid  = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        bus_inv_ack = 1'b1;
        @(negedge clk);
        bus_inv_ack = 1'b0;
    endtask

    task automatic expect_req(input string req, input logic [1:0] kind, input logic [ADDR_W-1:0] a);
        check(req, "bus_req_valid", 32'(bus_req_valid), 1);
        check(req, "bus_req_kind", 32'(bus_req_kind), 32'(kind));
        check(req, "bus_req_addr", 32'(bus_req_addr), 32'(a));
        check("R7", "ready while outstanding", 32'(cpu_req_ready), 0);
    endtask

    task automatic expect_state(input string req, input logic [ADDR_W-1:0] a,
                                input logic [1:0] exp_st, input logic [DATA_W-1:0] exp_d);
        logic [1:0] st;
        logic [DATA_W-1:0] d;
        snoop(1'b0, a, st, d);
        check(req, "snoop state", 32'(st), 32'(exp_st));
        check(req, "snoop data", d, exp_d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "ready after reset", 32'(cpu_req_ready), 1);
        check("R1", "bus idle", 32'(bus_req_valid), 0);
        check("R1", "no resp", 32'(cpu_resp_valid), 0);
        check("R1", "no snoop resp", 32'(snp_resp_valid), 0);
        expect_state("R1", mk(0, 0), 0, 0);
        expect_state("R1", mk(3, 1), 0, 0);
    endtask

    task automatic t_load_miss_clean();
        cpu_go(1'b0, mk(3, 1), 0);
        expect_req("R6", 1, mk(3, 1));
        check("R6", "no resp before fill", 32'(cpu_resp_valid), 0);
        repeat (2) @(negedge clk);
        expect_req("R6", 1, mk(3, 1));
        fill(1'b0, 32'hA1A1_0001);
        check("R6", "resp after fill", 32'(cpu_resp_valid), 1);
        check("R6", "fill word", cpu_resp_rdata, 32'hA1A1_0001);
        check("R6", "bus released", 32'(bus_req_valid), 0);
        cpu_go(1'b0, mk(3, 1), 0);
        check("R2", "hit resp", 32'(cpu_resp_valid), 1);
        check("R2", "hit word", cpu_resp_rdata, 32'hA1A1_0001);
        check("R2", "hit no bus", 32'(bus_req_valid), 0);
        expect_state("R6", mk(3, 1), 2, 0);
        expect_state("R8", mk(3, 1), 1, 0);
    endtask

    task automatic t_load_miss_shared();
        cpu_go(1'b0, mk(4, 2), 0);
        expect_req("R6", 1, mk(4, 2));
        fill(1'b1, 32'h0000_00B2);
        check("R6", "shared fill word", cpu_resp_rdata, 32'h0000_00B2);
        expect_state("R6", mk(4, 2), 1, 0);
    endtask

    task automatic t_store_hit_clean();
        cpu_go(1'b0, mk(5, 3), 0);
        fill(1'b0, 32'h5555_0003);
        cpu_go(1'b1, mk(5, 3), 32'hC3C3_C3C3);
        check("R3", "store hit resp", 32'(cpu_resp_valid), 1);
        check("R3", "store hit no bus", 32'(bus_req_valid), 0);
        cpu_go(1'b0, mk(5, 3), 0);
        check("R2", "dirty hit word", cpu_resp_rdata, 32'hC3C3_C3C3);
        expect_state("R3", mk(5, 3), 3, 32'hC3C3_C3C3);
        expect_state("R8", mk(5, 3), 1, 0);
    endtask

    task automatic t_upgrade();
        cpu_go(1'b1, mk(5, 3), 32'h0000_2222);
        expect_req("R4", 3, mk(5, 3));
        check("R4", "no resp before ack", 32'(cpu_resp_valid), 0);
        repeat (2) @(negedge clk);
        expect_req("R4", 3, mk(5, 3));
        expect_state("R4", mk(5, 3), 1, 0);
        expect_req("R4", 3, mk(5, 3));
        ack();
        check("R4", "resp after ack", 32'(cpu_resp_valid), 1);
        check("R4", "bus released", 32'(bus_req_valid), 0);
        expect_state("R4", mk(5, 3), 3, 32'h0000_2222);
    endtask

    task automatic t_store_miss();
        cpu_go(1'b1, mk(6, 4), 32'h0000_4444);
        expect_req("R5", 2, mk(6, 4));
        fill(1'b0, 32'hDEAD_BEEF);
        check("R5", "resp after fill", 32'(cpu_resp_valid), 1);
        expect_state("R8", mk(7, 4), 0, 0);
        cpu_go(1'b0, mk(6, 4), 0);
        check("R5", "store word kept", cpu_resp_rdata, 32'h0000_4444);
        expect_state("R5", mk(6, 4), 3, 32'h0000_4444);
    endtask

    task automatic t_invalidate();
        logic [1:0] st;
        logic [DATA_W-1:0] d;
        snoop(1'b1, mk(3, 1), st, d);
        check("R9", "inval prior state", 32'(st), 1);
        expect_state("R9", mk(3, 1), 0, 0);
        cpu_go(1'b0, mk(3, 1), 0);
        expect_req("R9", 1, mk(3, 1));
        fill(1'b1, 32'h0000_0099);
        check("R9", "refill word", cpu_resp_rdata, 32'h0000_0099);
    endtask

    task automatic t_race_before_ack();
        logic [1:0] st;
        logic [DATA_W-1:0] d;
        cpu_go(1'b1, mk(4, 2), 32'h0000_5555);
        expect_req("R10", 3, mk(4, 2));
        snoop(1'b1, mk(4, 2), st, d);
        check("R10", "killed line prior state", 32'(st), 1);
        expect_req("R10", 3, mk(4, 2));
        ack();
        check("R10", "no resp on stale ack", 32'(cpu_resp_valid), 0);
        expect_req("R10", 2, mk(4, 2));
        fill(1'b0, 32'h1111_1111);
        check("R10", "resp after refill", 32'(cpu_resp_valid), 1);
        expect_state("R10", mk(4, 2), 3, 32'h0000_5555);
    endtask

    task automatic t_race_same_cycle();
        cpu_go(1'b0, mk(8, 5), 0);
        fill(1'b1, 32'h0000_0055);
        cpu_go(1'b1, mk(8, 5), 32'h0000_6666);
        expect_req("R10", 3, mk(8, 5));
        @(negedge clk);
        bus_inv_ack = 1'b1;
        snp_valid   = 1'b1;
        snp_kind    = 1'b1;
        snp_addr    = mk(8, 5);
        @(negedge clk);
        bus_inv_ack = 1'b0;
        snp_valid   = 1'b0;
        check("R10", "same-cycle snoop state", 32'(snp_resp_state), 1);
        check("R10", "same-cycle no resp", 32'(cpu_resp_valid), 0);
        expect_req("R10", 2, mk(8, 5));
        fill(1'b1, 32'h0000_7777);
        expect_state("R10", mk(8, 5), 3, 32'h0000_6666);
    endtask

    task automatic t_fill_vs_snoop();
        cpu_go(1'b0, mk(9, 6), 0);
        fill(1'b0, 32'h0000_0909);
        cpu_go(1'b0, mk(10, 6), 0);
        expect_req("R11", 1, mk(10, 6));
        @(negedge clk);
        bus_fill_valid  = 1'b1;
        bus_fill_shared = 1'b1;
        bus_fill_data   = 32'h0000_0A0A;
        snp_valid       = 1'b1;
        snp_kind        = 1'b1;
        snp_addr        = mk(9, 6);
        @(negedge clk);
        bus_fill_valid  = 1'b0;
        snp_valid       = 1'b0;
        check("R11", "snoop saw old line", 32'(snp_resp_state), 2);
        check("R11", "fill resp", 32'(cpu_resp_valid), 1);
        check("R11", "fill word", cpu_resp_rdata, 32'h0000_0A0A);
        expect_state("R11", mk(10, 6), 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_miss_clean();
        t_load_miss_shared();
        t_store_hit_clean();
        t_upgrade();
        t_store_miss();
        t_invalidate();
        t_race_before_ack();
        t_race_same_cycle();
        t_fill_vs_snoop();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule